// File: doc/BRIEF.md
# YAGS Branch Direction Predictor

This block predicts whether a conditional branch is taken. A bias table of 2-bit saturating counters, indexed by the branch address, gives each branch its usual direction. Two small tagged caches keep only the cases where a branch goes against that usual direction. The taken-side cache serves branches whose bias is not-taken. The not-taken-side cache serves branches whose bias is taken. Both caches are indexed by the branch address XOR a global outcome history, so one branch can have different exceptions in different history contexts.

A fetch stage drives a branch address and reads the prediction in the same cycle. The prediction comes with the state it was made from: the bias direction, whether the probed cache hit, that cache's direction, and the history value. When the branch resolves, the pipeline hands this state back together with the real outcome. The block then trains the counters, allocates exception entries and shifts the history. Table size, tag width and address alignment are parameters. Setting the index width to 13 gives 8192 entries per table.

Top module: `yags_predictor`

## Requirements
- R1: After reset every bias and cache counter is 01 (weakly not-taken), every cache entry is invalid and the history is zero. Any address then predicts not-taken, and the reported hit and history are 0.
- R2: The bias counter is selected by address bits [ALIGN_W +: IDX_W]. Its MSB is the bias direction. It saturates at 00 and 11, and branches whose addresses differ only above those bits share it.
- R3: The cache index is the bias index XOR the history. The tag is address bits [ALIGN_W +: TAG_W]. A bias of taken probes the not-taken-side cache, and a bias of not-taken probes the taken-side cache. A hit needs the entry to be valid and its tag to match.
- R4: On a hit the prediction is the MSB of the cache entry's counter. Otherwise it is the bias direction.
- R5: The prediction and its reported state follow the predict address combinationally, in the same cycle, with no clock edge.
- R6: An update whose recorded state shows a hit moves that cache entry's counter one step toward the outcome, saturating.
- R7: An update that missed, with an outcome opposite to the bias, writes the probed cache entry: valid set, tag of the branch, and counter 10 if taken or 01 if not-taken.
- R8: An update that missed, with an outcome equal to the bias, writes no cache. An update never writes the cache that was not probed.
- R9: The bias counter moves one step toward the outcome on every update, except when the bias was wrong and a cache hit predicted the outcome correctly. In that case it is left unchanged.
- R10: On each update the history shifts left by one and takes the outcome (1 for taken) into bit 0. Without an update it holds its value.
- R11: An update becomes visible to predictions from the cycle after it is presented. A prediction in the same cycle sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_choice_taken | output | 1 | Bias direction read for pred_pc |
| pred_cache_hit | output | 1 | Probed cache held a valid matching entry |
| pred_cache_taken | output | 1 | Counter MSB of the probed cache entry |
| pred_ghr | output | IDX_W | Current global history |
| upd_valid | input | 1 | Apply a resolved branch this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_ghr | input | IDX_W | History recorded at prediction time |
| upd_choice_taken | input | 1 | Bias direction recorded at prediction time |
| upd_cache_hit | input | 1 | Cache hit recorded at prediction time |
| upd_cache_taken | input | 1 | Cache direction recorded at prediction time |

## Verification
A reference model follows each cycle with ordinary arrays and integers. Directed sequences drive one branch through the whole exception life cycle: the bias is trained taken, one not-taken outcome allocates an entry, a correct exception leaves the bias alone, and later taken outcomes retrain the entry. Runs of not-taken outcomes on a second branch bring the history back to zero between steps, which tells allocation apart from training. A third address shares the bias counter but not the tag, which separates tag matching from index sharing. A mixed random phase then covers strongly biased, alternating and irregular branches with idle cycles in between, so interaction between aliasing entries and the history is exercised.

// File: rtl/yags_pkg.sv
package yags_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT = 2'b01;
    localparam ctr2_t CTR_WEAK_T  = 2'b10;

    // one saturating step of a 2-bit counter toward the given direction
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t r;
        r = c;
        if (up) begin
            if (c != 2'b11) r = c + 2'd1;
        end else begin
            if (c != 2'b00) r = c - 2'd1;
        end
        return r;
    endfunction

    // counter value given to a freshly allocated exception entry
    function automatic ctr2_t ctr_weak(input logic up);
        return up ? CTR_WEAK_T : CTR_WEAK_NT;
    endfunction

endpackage

// File: rtl/yags_choice_table.sv
module yags_choice_table
    import yags_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr2_t ctr_q [DEPTH];
    ctr2_t ctr_d [DEPTH];

    always_comb begin
        ctr_d = ctr_q;
        if (wr_en) begin
            ctr_d[wr_idx] = ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_WEAK_NT;
            end
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign rd_taken = ctr_q[rd_idx][1];

endmodule

// File: rtl/yags_dir_cache.sv
module yags_dir_cache
    import yags_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic             rd_taken,
    input  logic             wr_train,
    input  logic             wr_alloc,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        ctr2_t            ctr;
    } entry_t;

    entry_t ent_q [DEPTH];
    entry_t ent_d [DEPTH];

    always_comb begin
        ent_d = ent_q;
        if (wr_alloc) begin
            ent_d[wr_idx].vld = 1'b1;
            ent_d[wr_idx].tag = wr_tag;
            ent_d[wr_idx].ctr = ctr_weak(wr_taken);
        end else if (wr_train) begin
            ent_d[wr_idx].ctr = ctr_step(ent_q[wr_idx].ctr, wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i].vld <= 1'b0;
                ent_q[i].tag <= '0;
                ent_q[i].ctr <= CTR_WEAK_NT;
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_hit   = ent_q[rd_idx].vld && (ent_q[rd_idx].tag == rd_tag);
    assign rd_taken = ent_q[rd_idx].ctr[1];

endmodule

// File: rtl/yags_update_ctrl.sv
module yags_update_ctrl (
    input  logic       upd_valid,
    input  logic       upd_taken,
    input  logic       upd_choice_taken,
    input  logic       upd_cache_hit,
    input  logic       upd_cache_taken,
    output logic       choice_wr,
    output logic [1:0] cache_train,   // [0] not-taken side, [1] taken side
    output logic [1:0] cache_alloc
);

    logic bias_wrong;
    logic exc_right;
    logic probe_nt;
    logic train_any;
    logic alloc_any;

    always_comb begin
        bias_wrong = (upd_choice_taken != upd_taken);
        exc_right  = upd_cache_hit && (upd_cache_taken == upd_taken);
        probe_nt   = upd_choice_taken;
        train_any  = upd_valid && upd_cache_hit;
        alloc_any  = upd_valid && !upd_cache_hit && bias_wrong;

        choice_wr      = upd_valid && !(bias_wrong && exc_right);
        cache_train[0] = train_any && probe_nt;
        cache_train[1] = train_any && !probe_nt;
        cache_alloc[0] = alloc_any && probe_nt;
        cache_alloc[1] = alloc_any && !probe_nt;
    end

endmodule

// File: rtl/yags_predictor.sv
module yags_predictor
    import yags_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 10,
    parameter int TAG_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic             pred_choice_taken,
    output logic             pred_cache_hit,
    output logic             pred_cache_taken,
    output logic [IDX_W-1:0] pred_ghr,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [IDX_W-1:0] upd_ghr,
    input  logic             upd_choice_taken,
    input  logic             upd_cache_hit,
    input  logic             upd_cache_taken
);

    localparam int TAG_LO = ALIGN_W;
    localparam int TAG_HI = ALIGN_W + TAG_W;

    typedef struct packed {
        logic [IDX_W-1:0] ghr;
    } hist_t;

    hist_t hist_q;
    hist_t hist_d;

    logic [IDX_W-1:0] pred_cidx;
    logic [IDX_W-1:0] pred_xidx;
    logic [TAG_W-1:0] pred_tag;
    logic [IDX_W-1:0] upd_cidx;
    logic [IDX_W-1:0] upd_xidx;
    logic [TAG_W-1:0] upd_tag;

    logic             choice_rd_taken;
    logic             choice_wr_en;
    logic [1:0]       train_v;
    logic [1:0]       alloc_v;
    logic [1:0]       rd_hit_v;
    logic [1:0]       rd_taken_v;

    logic             unused_pc_bits;

    assign pred_cidx = pred_pc[ALIGN_W +: IDX_W];
    assign pred_tag  = pred_pc[ALIGN_W +: TAG_W];
    assign pred_xidx = pred_cidx ^ hist_q.ghr;
    assign upd_cidx  = upd_pc[ALIGN_W +: IDX_W];
    assign upd_tag   = upd_pc[ALIGN_W +: TAG_W];
    assign upd_xidx  = upd_cidx ^ upd_ghr;

    assign unused_pc_bits = ^{pred_pc[PC_W-1:TAG_HI], pred_pc[TAG_LO-1:0],
                              upd_pc[PC_W-1:TAG_HI],  upd_pc[TAG_LO-1:0]};

    yags_choice_table #(
        .IDX_W (IDX_W)
    ) u_choice (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_cidx),
        .rd_taken (choice_rd_taken),
        .wr_en    (choice_wr_en),
        .wr_idx   (upd_cidx),
        .wr_taken (upd_taken)
    );

    yags_update_ctrl u_ctrl (
        .upd_valid        (upd_valid),
        .upd_taken        (upd_taken),
        .upd_choice_taken (upd_choice_taken),
        .upd_cache_hit    (upd_cache_hit),
        .upd_cache_taken  (upd_cache_taken),
        .choice_wr        (choice_wr_en),
        .cache_train      (train_v),
        .cache_alloc      (alloc_v)
    );

    // side 0 holds exceptions of taken-biased branches, side 1 of not-taken-biased
    for (genvar g = 0; g < 2; g++) begin : g_side
        yags_dir_cache #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
        ) u_cache (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (pred_xidx),
            .rd_tag   (pred_tag),
            .rd_hit   (rd_hit_v[g]),
            .rd_taken (rd_taken_v[g]),
            .wr_train (train_v[g]),
            .wr_alloc (alloc_v[g]),
            .wr_idx   (upd_xidx),
            .wr_tag   (upd_tag),
            .wr_taken (upd_taken)
        );
    end

    always_comb begin
        pred_choice_taken = choice_rd_taken;
        pred_cache_hit    = choice_rd_taken ? rd_hit_v[0]   : rd_hit_v[1];
        pred_cache_taken  = choice_rd_taken ? rd_taken_v[0] : rd_taken_v[1];
        pred_taken        = pred_cache_hit ? pred_cache_taken : choice_rd_taken;
        pred_ghr          = hist_q.ghr;
    end

    always_comb begin
        hist_d = hist_q;
        if (upd_valid) begin
            hist_d.ghr = {hist_q.ghr[IDX_W-2:0], upd_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/yags_predictor_chk.sv
module yags_predictor_chk #(
    parameter int GHR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic             upd_choice_taken,
    input logic             upd_cache_hit,
    input logic             upd_cache_taken,
    input logic [GHR_W-1:0] pred_ghr,
    input logic             pred_taken,
    input logic             pred_choice_taken,
    input logic             pred_cache_hit,
    input logic             choice_wr,
    input logic             nt_wr,
    input logic             t_wr
);

    assert_ghr_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_ghr == {$past(pred_ghr[GHR_W-2:0]), $past(upd_taken)});

    assert_ghr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pred_ghr));

    assert_single_cache_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nt_wr, t_wr}));

    assert_nt_side_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nt_wr |-> upd_choice_taken);

    assert_t_side_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t_wr |-> !upd_choice_taken);

    assert_no_alloc_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_cache_hit && (upd_taken == upd_choice_taken)) |-> !(nt_wr || t_wr));

    assert_choice_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_cache_hit && (upd_cache_taken == upd_taken)
         && (upd_choice_taken != upd_taken)) |-> !choice_wr);

    assert_choice_train_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_cache_hit) |-> choice_wr);

    assert_fallback_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_cache_hit |-> (pred_taken == pred_choice_taken));

endmodule

bind yags_predictor yags_predictor_chk #(
    .GHR_W (IDX_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .upd_valid         (upd_valid),
    .upd_taken         (upd_taken),
    .upd_choice_taken  (upd_choice_taken),
    .upd_cache_hit     (upd_cache_hit),
    .upd_cache_taken   (upd_cache_taken),
    .pred_ghr          (pred_ghr),
    .pred_taken        (pred_taken),
    .pred_choice_taken (pred_choice_taken),
    .pred_cache_hit    (pred_cache_hit),
    .choice_wr         (choice_wr_en),
    .nt_wr             (train_v[0] | alloc_v[0]),
    .t_wr              (train_v[1] | alloc_v[1])
);

// File: tb/yags_predictor_bench.sv
module yags_predictor_bench;

    localparam int PC_W    = 32;
    localparam int ALIGN_W = 2;
    localparam int IDX_W   = 10;
    localparam int TAG_W   = 13;
    localparam int NENT    = 1 << IDX_W;

    localparam logic [31:0] PC_A = 32'h0000_1000;
    localparam logic [31:0] PC_B = 32'h0000_2344;
    localparam logic [31:0] PC_C = 32'h0000_2000;   // same bias slot as PC_A, other tag

    logic             clk = 1'b0;
    logic             rst_n;
    logic [PC_W-1:0]  pred_pc;
    logic             pred_taken;
    logic             pred_choice_taken;
    logic             pred_cache_hit;
    logic             pred_cache_taken;
    logic [IDX_W-1:0] pred_ghr;
    logic             upd_valid;
    logic [PC_W-1:0]  upd_pc;
    logic             upd_taken;
    logic [IDX_W-1:0] upd_ghr;
    logic             upd_choice_taken;
    logic             upd_cache_hit;
    logic             upd_cache_taken;

    always #10 clk = ~clk;

    yags_predictor #(
        .PC_W    (PC_W),
        .ALIGN_W (ALIGN_W),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W)
    ) u_yags_predictor (
        .clk               (clk),
        .rst_n             (rst_n),
        .pred_pc           (pred_pc),
        .pred_taken        (pred_taken),
        .pred_choice_taken (pred_choice_taken),
        .pred_cache_hit    (pred_cache_hit),
        .pred_cache_taken  (pred_cache_taken),
        .pred_ghr          (pred_ghr),
        .upd_valid         (upd_valid),
        .upd_pc            (upd_pc),
        .upd_taken         (upd_taken),
        .upd_ghr           (upd_ghr),
        .upd_choice_taken  (upd_choice_taken),
        .upd_cache_hit     (upd_cache_hit),
        .upd_cache_taken   (upd_cache_taken)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference state: side 0 = not-taken-side cache, side 1 = taken-side cache
    int m_ch  [NENT];
    bit m_v   [2][NENT];
    int m_tag [2][NENT];
    int m_c   [2][NENT];
    int m_ghr;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int c, input bit up);
        if (up) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NENT; i++) begin
            m_ch[i] = 1;
            for (int s = 0; s < 2; s++) begin
                m_v[s][i]   = 1'b0;
                m_tag[s][i] = 0;
                m_c[s][i]   = 1;
            end
        end
        m_ghr = 0;
    endtask

    // one cycle: predict pc, compare with the model, optionally resolve it
    task automatic step(input logic [31:0] pc, input bit valid, input bit outc);
        int ci, tg, xi, side;
        bit ch, hit, ct, pt;
        ci   = int'((pc >> ALIGN_W) % NENT);
        tg   = int'((pc >> ALIGN_W) % (1 << TAG_W));
        xi   = ci ^ m_ghr;
        ch   = (m_ch[ci] >= 2);
        side = ch ? 0 : 1;
        hit  = m_v[side][xi] && (m_tag[side][xi] == tg);
        ct   = (m_c[side][xi] >= 2);
        pt   = hit ? ct : ch;
        pred_pc          = pc;
        upd_pc           = pc;
        upd_valid        = valid;
        upd_taken        = outc;
        upd_ghr          = IDX_W'(m_ghr);
        upd_choice_taken = ch;
        upd_cache_hit    = hit;
        upd_cache_taken  = ct;
        #1;
        chk("R2", "bias", 32'(pred_choice_taken), 32'(ch));
        chk("R3", "hit", 32'(pred_cache_hit), 32'(hit));
        chk("R6", "cache dir", 32'(pred_cache_taken), 32'(ct));
        chk("R4/R11", "prediction", 32'(pred_taken), 32'(pt));
        chk("R10", "history", 32'(pred_ghr), 32'(m_ghr));
        if (valid) begin
            if (hit) begin
                m_c[side][xi] = sat(m_c[side][xi], outc);
            end else if (outc != ch) begin
                m_v[side][xi]   = 1'b1;
                m_tag[side][xi] = tg;
                m_c[side][xi]   = outc ? 2 : 1;
            end
            if (!((ch != outc) && hit && (ct == outc))) begin
                m_ch[ci] = sat(m_ch[ci], outc);
            end
            m_ghr = ((m_ghr << 1) | int'(outc)) % NENT;
        end
        @(negedge clk);
    endtask

    task automatic probe(input logic [31:0] pc);
        pred_pc   = pc;
        upd_valid = 1'b0;
        #1;
    endtask

    // not-taken runs on PC_B bring the history back to zero without allocating
    task automatic clear_history();
        for (int i = 0; i < IDX_W; i++) begin
            step(PC_B, 1'b1, 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n            = 1'b0;
        pred_pc          = '0;
        upd_valid        = 1'b0;
        upd_pc           = '0;
        upd_taken        = 1'b0;
        upd_ghr          = '0;
        upd_choice_taken = 1'b0;
        upd_cache_hit    = 1'b0;
        upd_cache_taken  = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe(PC_A);
        chk("R1", "pred after reset", 32'(pred_taken), 0);
        chk("R1", "hit after reset", 32'(pred_cache_hit), 0);
        chk("R1", "bias after reset", 32'(pred_choice_taken), 0);
        chk("R1", "history after reset", 32'(pred_ghr), 0);
        probe(PC_C);
        chk("R1", "pred after reset C", 32'(pred_taken), 0);

        // train PC_A's bias to strongly taken
        step(PC_A, 1'b1, 1'b1);
        step(PC_A, 1'b1, 1'b1);
        clear_history();
        probe(PC_B);
        chk("R8", "agreeing miss leaves no entry", 32'(pred_cache_hit), 0);
        chk("R10", "history cleared", 32'(pred_ghr), 0);

        // exception: not-taken against a taken bias allocates
        step(PC_A, 1'b1, 1'b0);
        probe(PC_A);
        chk("R7", "allocated entry hits", 32'(pred_cache_hit), 1);
        chk("R7", "allocated counter weak not-taken", 32'(pred_cache_taken), 0);
        chk("R4", "prediction from cache", 32'(pred_taken), 0);
        chk("R9", "bias trained but still taken", 32'(pred_choice_taken), 1);

        // correct exception must leave the bias alone
        step(PC_A, 1'b1, 1'b0);
        probe(PC_A);
        chk("R9", "bias kept on correct exception", 32'(pred_choice_taken), 1);
        chk("R4", "still predicts not-taken", 32'(pred_taken), 0);

        // retrain the exception entry toward taken
        step(PC_A, 1'b1, 1'b1);
        clear_history();
        step(PC_A, 1'b1, 1'b1);
        clear_history();
        probe(PC_A);
        chk("R6", "entry trained to taken", 32'(pred_cache_taken), 1);
        chk("R6", "entry still hits", 32'(pred_cache_hit), 1);
        chk("R4", "prediction follows entry", 32'(pred_taken), 1);

        // R5: combinational follow of the predict address
        pred_pc = PC_B;
        #1;
        chk("R5", "same-cycle switch to B", 32'(pred_taken), 0);
        pred_pc = PC_A;
        #1;
        chk("R5", "same-cycle switch to A", 32'(pred_taken), 1);

        // shared bias slot, different tag
        probe(PC_C);
        chk("R2", "shared bias slot", 32'(pred_choice_taken), 1);
        chk("R3", "tag mismatch misses", 32'(pred_cache_hit), 0);
        chk("R4", "miss falls back to bias", 32'(pred_taken), 1);

        // idle cycles hold the history
        step(PC_A, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(PC_C, 1'b0, 1'b0);
        probe(PC_A);
        chk("R10", "history held while idle", 32'(pred_ghr), 1);

        // mixed random phase
        for (int n = 0; n < 3000; n++) begin
            int k;
            bit o;
            logic [31:0] pc;
            k  = $urandom_range(0, 7);
            pc = 32'h0000_4000 + 32'(k) * 32'h0000_0104;
            case (k % 4)
                0:       o = ($urandom_range(0, 99) < 92);
                1:       o = ($urandom_range(0, 99) < 8);
                2:       o = n[0];
                default: o = ($urandom_range(0, 1) == 1);
            endcase
            step(pc, ($urandom_range(0, 9) != 0), o);
        end

        finish_run();
    end

endmodule